// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wraparound

This block sits between the command front end of a serial non-volatile memory and its storage array. While an array-write command is in progress it collects the incoming bytes into a one-page staging buffer. The buffer records a loaded flag for every byte slot. The start address of the command selects the page through its upper bits and the first byte slot through its lower bits. Each further byte goes to the next slot. After the last slot of the page the slot pointer returns to slot 0 of the same page, so a long command overwrites its own earliest bytes.

When the front end signals the end of the command, the block checks two things: the protection unit's write-allowed flag, and whether at least one byte was loaded. If both hold, it starts a self-timed programming cycle of a fixed number of clocks and holds busy for the whole cycle. During the cycle it walks the page slots and copies only the loaded bytes into the register-based array through its write port. Bytes that were not loaded keep their old contents. A one-clock done pulse follows the cycle, and the surrounding logic uses it to clear its write-enable latch. A read port gives the array contents to the read path.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy, cycle_done and arr_we are low and every array byte reads 0.
- R2: The first byte after ld_start lands at array address ld_addr. Each following byte lands at the next byte slot of the same page. The page is ld_addr[ADDR_W-1:6] and the slot is ld_addr[5:0], with 64-byte pages by default.
- R3: After slot 63 of a page has been loaded, the next byte goes to slot 0 of the same page. No byte is ever written to another page.
- R4: When more than 64 bytes arrive in one command, each slot holds the last byte delivered to it, so exactly the final 64 bytes are kept.
- R5: A committed cycle changes only the loaded slots. All other array bytes, in that page and in every other page, keep their previous values.
- R6: An accepted commit raises busy on the next clock. Busy then stays high for exactly CYCLE_CLKS clocks.
- R7: cycle_done is high for exactly one clock, on the clock right after busy falls. It is never high at any other time.
- R8: A commit with wr_allowed low starts no cycle, produces no cycle_done and leaves the array unchanged.
- R9: A commit with no byte loaded since the last ld_start starts no cycle. The loaded flags are also cleared after any dropped commit.
- R10: While busy is high, ld_start, ld_valid and commit have no effect. Bytes offered during the cycle are never programmed, and a commit after the cycle with no new loading starts nothing.
- R11: arr_we is high only while busy. Across one cycle it is high exactly once for each distinct loaded slot, and every write in a cycle goes to the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_start | input | 1 | Begin a new command: latch ld_addr and clear the loaded flags |
| ld_addr | input | ADDR_W | Start address of the command |
| ld_valid | input | 1 | One data byte is present on ld_data |
| ld_data | input | DATA_W | Data byte to stage |
| commit | input | 1 | End of command, a request to program |
| wr_allowed | input | 1 | Protection unit allows this write (enable set, page not protected) |
| busy | output | 1 | Programming cycle in progress |
| cycle_done | output | 1 | One-clock pulse when a cycle ends; clears write enable |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte at rd_addr |

## Verification
The bench sweeps every page with commands of 1, 7, 64, 70 and 129 bytes. Each command starts at a slot derived from the page and the length, so short runs show correct placement, runs that cross slot 63 show the in-page wrap, and runs over 64 bytes show that the last writer wins. Every commit is followed by a full compare of the array against an arithmetic model, which catches stray writes to other pages or to unloaded slots. Commits with the write-allowed flag low, with nothing loaded, and with traffic offered during a busy cycle separate the three ways a request can be dropped. The busy length, the done pulse and the number of write strobes are also counted against the expected values on every accepted cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    // Sequencer phase, kept explicit for readability of the next-state logic.
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } pwb_phase_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        start_addr,
    input  logic                     push,
    input  logic [DATA_W-1:0]        push_data,
    input  logic                     clear,
    input  logic [PAGE_W-1:0]        slot_sel,
    output logic [ADDR_W-PAGE_W-1:0] page_base,
    output logic [DATA_W-1:0]        slot_data,
    output logic                     slot_loaded,
    output logic                     any_loaded
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [PG_W-1:0]                    page;
        logic [PAGE_W-1:0]                  ptr;
        logic [PAGE_BYTES-1:0]              mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  data;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.mask = '0;
        end
        if (!lock) begin
            if (start) begin
                st_d.page = start_addr[ADDR_W-1:PAGE_W];
                st_d.ptr  = start_addr[PAGE_W-1:0];
                st_d.mask = '0;
            end else if (push) begin
                st_d.data[st_q.ptr] = push_data;
                st_d.mask[st_q.ptr] = 1'b1;
                // natural PAGE_W-bit overflow keeps the pointer in the page
                st_d.ptr            = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_base   = st_q.page;
    assign slot_data   = st_q.data[slot_sel];
    assign slot_loaded = st_q.mask[slot_sel];
    assign any_loaded  = |st_q.mask;
endmodule

// File: rtl/pwb_prog_seq.sv
module pwb_prog_seq
    import pwb_pkg::*;
#(
    parameter int PAGE_W     = 6,
    parameter int CYCLE_CLKS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              allowed,
    input  logic              any_loaded,
    input  logic              slot_loaded,
    output logic [PAGE_W-1:0] slot_sel,
    output logic              slot_we,
    output logic              clear_buf,
    output logic              busy,
    output logic              done
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CYCLE_CLKS - 1);
    localparam logic [CNT_W-1:0] SLOT_LIM  = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        pwb_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       clr_c;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_c     = 1'b0;
        unique case (st_q.phase)
            PH_PROG: begin
                if (st_q.cnt == LAST_CNT) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                    clr_c      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                if (commit) begin
                    if (allowed && any_loaded) begin
                        st_d.phase = PH_PROG;
                        st_d.cnt   = '0;
                    end else begin
                        clr_c = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase == PH_PROG);
    assign done      = st_q.done;
    assign clear_buf = clr_c;
    assign slot_sel  = st_q.cnt[PAGE_W-1:0];
    assign slot_we   = busy && (st_q.cnt < SLOT_LIM) && slot_loaded;
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_W     = 6,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              commit,
    input  logic              wr_allowed,
    output logic              busy,
    output logic              cycle_done,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic [PG_W-1:0]   page_base;
    logic [PAGE_W-1:0] slot_sel;
    logic [DATA_W-1:0] slot_data;
    logic              slot_loaded;
    logic              any_loaded;
    logic              clear_buf;
    logic              slot_we;
    logic              busy_w;

    pwb_page_buf #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock        (busy_w),
        .start       (ld_start),
        .start_addr  (ld_addr),
        .push        (ld_valid),
        .push_data   (ld_data),
        .clear       (clear_buf),
        .slot_sel    (slot_sel),
        .page_base   (page_base),
        .slot_data   (slot_data),
        .slot_loaded (slot_loaded),
        .any_loaded  (any_loaded)
    );

    pwb_prog_seq #(
        .PAGE_W     (PAGE_W),
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .allowed     (wr_allowed),
        .any_loaded  (any_loaded),
        .slot_loaded (slot_loaded),
        .slot_sel    (slot_sel),
        .slot_we     (slot_we),
        .clear_buf   (clear_buf),
        .busy        (busy_w),
        .done        (cycle_done)
    );

    pwb_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (slot_we),
        .waddr ({page_base, slot_sel}),
        .wdata (slot_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy     = busy_w;
    assign arr_we   = slot_we;
    assign arr_addr = {page_base, slot_sel};
    assign arr_data = slot_data;
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_W     = 6,
    parameter int CYCLE_CLKS = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              busy,
    input logic              cycle_done,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    localparam int RUN_W = $clog2(CYCLE_CLKS + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_BUSY_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit)); // R6

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(CYCLE_CLKS))); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (!busy && $past(busy))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R7

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R11

    AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && busy && $past(arr_we) && $past(busy))
            |-> (arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W]))); // R3
endmodule

bind page_write_buffer page_write_buffer_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .busy       (busy),
    .cycle_done (cycle_done),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr)
);

// File: tb/test_page_write_buffer.sv
`timescale 1ns/1ps
module test_page_write_buffer;
    localparam int AW  = 8;
    localparam int PW  = 6;
    localparam int DW  = 8;
    localparam int CC  = 80;
    localparam int NB  = 1 << AW;
    localparam int PB  = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_start = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_valid = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic          commit = 1'b0;
    logic          wr_allowed = 1'b0;
    logic          busy, cycle_done, arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [NB];
    logic [DW-1:0] pbuf  [PB];
    logic          pmask [PB];
    int            ppage, pptr;

    always #4 clk = ~clk;

    page_write_buffer #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .CYCLE_CLKS(CC)) i_page_write_buffer (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
        .ld_valid(ld_valid), .ld_data(ld_data), .commit(commit), .wr_allowed(wr_allowed),
        .busy(busy), .cycle_done(cycle_done), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_array(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < NB; a++) begin
            rd_addr = AW'(a);
            #0.01;
            if (rd_data !== model[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            rd_addr = AW'(first);
            #0.01;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d (%0d bytes differ)",
                     req, first, rd_data, model[first], bad);
        end
    endtask

    task automatic do_start(input int addr);
        ld_start = 1'b1;
        ld_addr  = AW'(addr);
        @(negedge clk);
        ld_start = 1'b0;
        ppage = addr >> PW;
        pptr  = addr % PB;
        for (int s = 0; s < PB; s++) pmask[s] = 1'b0;
    endtask

    task automatic do_push(input int b);
        ld_valid = 1'b1;
        ld_data  = DW'(b);
        @(negedge clk);
        ld_valid = 1'b0;
        pbuf[pptr]  = DW'(b);
        pmask[pptr] = 1'b1;
        pptr = (pptr + 1) % PB;
    endtask

    // commit and follow an expected accepted cycle
    task automatic commit_accept(input string req);
        int bad_busy = 0;
        int we_cnt = 0;
        int exp_we = 0;
        int bad_page = 0;
        commit = 1'b1;
        wr_allowed = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        for (int i = 0; i < CC; i++) begin
            if (busy !== 1'b1 || cycle_done !== 1'b0) bad_busy++;
            if (arr_we === 1'b1) begin
                we_cnt++;
                if ((int'(arr_addr) >> PW) != ppage) bad_page++;
            end
            @(negedge clk);
        end
        chk({req, " R6 busy held CYCLE_CLKS"}, bad_busy, 0);
        chk({req, " R6 busy falls"}, int'(busy), 0);
        chk({req, " R7 done pulse"}, int'(cycle_done), 1);
        for (int s = 0; s < PB; s++) begin
            if (pmask[s]) begin
                exp_we++;
                model[ppage * PB + s] = pbuf[s];
            end
        end
        chk({req, " R11 write strobes"}, we_cnt, exp_we);
        chk({req, " R3 writes in page"}, bad_page, 0);
        @(negedge clk);
        chk({req, " R7 done single"}, int'(cycle_done), 0);
        for (int s = 0; s < PB; s++) pmask[s] = 1'b0;
    endtask

    task automatic commit_drop(input string req, input logic allowed);
        int bad = 0;
        commit = 1'b1;
        wr_allowed = allowed;
        @(negedge clk);
        commit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (busy !== 1'b0 || cycle_done !== 1'b0 || arr_we !== 1'b0) bad++;
            @(negedge clk);
        end
        chk({req, " no cycle"}, bad, 0);
        for (int s = 0; s < PB; s++) pmask[s] = 1'b0;
    endtask

    initial begin
        #(8.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NB; a++) model[a] = '0;
        for (int s = 0; s < PB; s++) begin pmask[s] = 1'b0; pbuf[s] = '0; end
        ppage = 0; pptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(cycle_done), 0);
        chk("R1 we", int'(arr_we), 0);
        check_array("R1 array zero");

        // R2/R3/R4/R5 sweep over pages, lengths and start slots
        for (int seed = 0; seed < 2; seed++) begin
            for (int pg = 0; pg < NB / PB; pg++) begin
                for (int li = 0; li < 5; li++) begin
                    int len;
                    int off;
                    len = (li == 0) ? 1 : (li == 1) ? 7 : (li == 2) ? 64 : (li == 3) ? 70 : 129;
                    off = (pg * 13 + len * 3 + seed * 29) % PB;
                    do_start(pg * PB + off);
                    for (int i = 0; i < len; i++)
                        do_push((pg * 37 + off * 5 + i * 11 + seed * 91 + len) & 8'hFF);
                    commit_accept("R2 R3 R4 sweep");
                    check_array("R5 R2 R3 R4 array contents");
                end
            end
        end

        // R8: write not allowed
        do_start(2 * PB + 10);
        for (int i = 0; i < 5; i++) do_push(8'hA5 ^ i);
        commit_drop("R8 not allowed", 1'b0);
        check_array("R8 array unchanged");

        // R9: nothing loaded
        do_start(PB + 3);
        commit_drop("R9 zero bytes", 1'b1);
        // R9: dropped commit cleared the flags; commit again without loading
        do_start(3 * PB + 1);
        for (int i = 0; i < 3; i++) do_push(8'h3C + i);
        commit_drop("R9 setup drop", 1'b0);
        commit_drop("R9 flags cleared", 1'b1);
        check_array("R9 array unchanged");

        // R10: traffic during a busy cycle is ignored
        do_start(PB + 60);
        for (int i = 0; i < 8; i++) do_push(8'hC0 + i);
        commit = 1'b1; wr_allowed = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk("R10 cycle started", int'(busy), 1);
        repeat (3) @(negedge clk);
        ld_start = 1'b1; ld_addr = AW'(0);
        @(negedge clk);
        ld_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ld_valid = 1'b1; ld_data = DW'(8'h77 + i);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        begin
            int guard = 0;
            while (busy === 1'b1 && guard < 4 * CC) begin
                @(negedge clk);
                guard++;
            end
        end
        for (int s = 0; s < PB; s++)
            if (pmask[s]) model[ppage * PB + s] = pbuf[s];
        for (int s = 0; s < PB; s++) pmask[s] = 1'b0;
        chk("R10 cycle ended", int'(busy), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 no second cycle", int'(busy), 0);
        commit_drop("R10 busy loads ignored", 1'b1);
        check_array("R10 array holds only first command");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule